// File: doc/BRIEF.md
# Serial Bus Collision Detector

This block watches a shared serial line, either single-wire or wired-AND, while a frame is being sent. At each sampling instant it compares the level the local transmitter drives on TXD with the level read back on RXD. When the two differ during a transmission, it sets a sticky collision interrupt request. The sampling instant comes from one of two sources, selected by a control bit: the rising edge of the transfer clock, or an overflow strobe from an external timer.

Two optional behaviours sit around the comparison. A collision can clear the transmit enable automatically, so the transmitter stops driving a line it has lost. Transmission start can also be held back after arming until a falling edge appears on RXD. The transfer clock, the timer strobe and RXD are asynchronous to the system clock, so each passes through a two-flop synchronizer, and edges are found by comparing the synchronized level with its previous value. The shift register and the timer sit outside this block.

Top module: `bus_collision_guard`

## Requirements
- R1: After reset, the control bits, the transmit enable (tx_en_o), the transmit-start qualifier (tx_start_ok_o) and the collision request (coll_irq_o) are all 0.
- R2: Register writes (reg_wr_i high for one cycle) decode reg_addr_i as follows. Address 0 loads control: bit 4 is the sampling source, bit 5 is auto-clear and bit 6 is start-on-RXD-fall. Address 1 loads the transmit enable from data bit 0. Address 2 with data bit 0 set clears the collision request.
- R3: With control bit 4 = 0 and tx_busy_i high, a rising edge of xfer_clk_i while txd_i differs from rxd_i sets coll_irq_o. If the levels match at that edge, nothing is set.
- R4: With control bit 4 = 0, pulses on tmr_ovf_i never set coll_irq_o.
- R5: With control bit 4 = 1, a tmr_ovf_i pulse samples the mismatch in the same way, and rising edges of xfer_clk_i never set coll_irq_o.
- R6: While tx_busy_i is low, no sampling strobe sets coll_irq_o.
- R7: coll_irq_o stays set until a clear write to address 2. A write to address 2 with data bit 0 = 0 has no effect. If a new collision lands in the same cycle as a clear, the request stays set.
- R8: With control bit 5 = 1, tx_en_o drops to 0 in the same cycle in which coll_irq_o becomes set.
- R9: With control bit 5 = 0, a collision leaves tx_en_o unchanged.
- R10: With control bit 6 = 0, tx_start_ok_o equals tx_en_o.
- R11: With control bit 6 = 1, tx_start_ok_o rises only after an RXD falling edge that arrives while tx_en_o is already high. Falls before arming do not count, and the qualifier drops as soon as tx_en_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| xfer_clk_i | input | 1 | Serial transfer clock (asynchronous) |
| tmr_ovf_i | input | 1 | External timer overflow strobe (asynchronous) |
| tx_busy_i | input | 1 | High while a frame is being transmitted |
| txd_i | input | 1 | Level driven on the transmit pin |
| rxd_i | input | 1 | Level read back on the receive pin (asynchronous) |
| tx_en_o | output | 1 | Transmit enable |
| tx_start_ok_o | output | 1 | Transmission may start |
| coll_irq_o | output | 1 | Collision interrupt request |

## Verification
The bench builds the block with its default two-stage synchronizers and an 8-bit write port. At these values, the latency from an input edge to the updated request is three clock edges, so the exact cycle can be targeted and a collision can be made to coincide with a clear write. Random rounds mix the sampling source, the strobe kind, the busy flag, the line levels and auto-clear. Directed cases cover the sticky clear, the ignored strobes and the arming order of the RXD-fall start gate.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
  localparam int unsigned REG_ADDR_W = 2;
  localparam int unsigned REG_DATA_W = 8;
  localparam logic [REG_ADDR_W-1:0] ADDR_CTRL   = 2'd0;
  localparam logic [REG_ADDR_W-1:0] ADDR_TXEN   = 2'd1;
  localparam logic [REG_ADDR_W-1:0] ADDR_IRQCLR = 2'd2;
  localparam int unsigned BIT_SMP_TMR  = 4;
  localparam int unsigned BIT_AUTO_CLR = 5;
  localparam int unsigned BIT_RX_START = 6;

  typedef struct packed {
    logic rx_start;
    logic auto_clr;
    logic smp_tmr;
  } ctrl_t;
endpackage

// File: rtl/bcd_sync.sv
module bcd_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] pipe_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pipe_q <= {STAGES{RST_VAL}};
      prev_q <= RST_VAL;
    end else begin
      pipe_q <= {pipe_q[STAGES-2:0], d_i};
      prev_q <= pipe_q[STAGES-1];
    end
  end

  assign level_o = pipe_q[STAGES-1];
  assign rise_o  = level_o & ~prev_q;
  assign fall_o  = ~level_o & prev_q;
endmodule

// File: rtl/bcd_collide.sv
module bcd_collide (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic smp_tmr_i,
  input  logic xfer_rise_i,
  input  logic tmr_rise_i,
  input  logic busy_i,
  input  logic txd_i,
  input  logic rxd_i,
  input  logic clr_i,
  output logic set_o,
  output logic irq_o
);
  logic strobe;

  assign strobe = smp_tmr_i ? tmr_rise_i : xfer_rise_i;
  assign set_o  = busy_i & strobe & (txd_i ^ rxd_i);

  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= set_o | (irq_o & ~clr_i);
  end
endmodule

// File: rtl/bcd_start_gate.sv
module bcd_start_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tx_en_i,
  input  logic rx_start_i,
  input  logic rx_fall_i,
  output logic start_ok_o
);
  logic seen_q;

  // edge memory is only armed while enable is already high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        seen_q <= 1'b0;
    else if (!tx_en_i)  seen_q <= 1'b0;
    else if (rx_fall_i) seen_q <= 1'b1;
  end

  assign start_ok_o = tx_en_i & (~rx_start_i | seen_q);
endmodule

// File: rtl/bus_collision_guard.sv
module bus_collision_guard
  import bcd_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ADDR_W      = REG_ADDR_W,
  parameter int unsigned DATA_W      = REG_DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  input  logic              xfer_clk_i,
  input  logic              tmr_ovf_i,
  input  logic              tx_busy_i,
  input  logic              txd_i,
  input  logic              rxd_i,
  output logic              tx_en_o,
  output logic              tx_start_ok_o,
  output logic              coll_irq_o
);
  localparam int unsigned NSYNC = 3;
  localparam int unsigned IDX_XFER = 0;
  localparam int unsigned IDX_TMR  = 1;
  localparam int unsigned IDX_RXD  = 2;
  localparam logic [NSYNC-1:0] SYNC_RST = 3'b100;

  ctrl_t            ctrl_q;
  logic             tx_en_q;
  logic [NSYNC-1:0] sync_in, sync_lvl, sync_rise, sync_fall;
  logic             wr_ctrl, wr_txen, wr_clr;
  logic             coll_set;

  assign sync_in = {rxd_i, tmr_ovf_i, xfer_clk_i};

  for (genvar g = 0; g < NSYNC; g++) begin : g_sync
    bcd_sync #(
      .STAGES (SYNC_STAGES),
      .RST_VAL(SYNC_RST[g])
    ) i_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (sync_in[g]),
      .level_o(sync_lvl[g]),
      .rise_o (sync_rise[g]),
      .fall_o (sync_fall[g])
    );
  end

  assign wr_ctrl = reg_wr_i && (reg_addr_i == ADDR_CTRL);
  assign wr_txen = reg_wr_i && (reg_addr_i == ADDR_TXEN);
  assign wr_clr  = reg_wr_i && (reg_addr_i == ADDR_IRQCLR) && reg_wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_q.smp_tmr  <= reg_wdata_i[BIT_SMP_TMR];
      ctrl_q.auto_clr <= reg_wdata_i[BIT_AUTO_CLR];
      ctrl_q.rx_start <= reg_wdata_i[BIT_RX_START];
    end
  end

  // auto-clear overrides a same-cycle software write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         tx_en_q <= 1'b0;
    else if (coll_set && ctrl_q.auto_clr) tx_en_q <= 1'b0;
    else if (wr_txen)                    tx_en_q <= reg_wdata_i[0];
  end

  bcd_collide i_collide (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .smp_tmr_i  (ctrl_q.smp_tmr),
    .xfer_rise_i(sync_rise[IDX_XFER]),
    .tmr_rise_i (sync_rise[IDX_TMR]),
    .busy_i     (tx_busy_i),
    .txd_i      (txd_i),
    .rxd_i      (sync_lvl[IDX_RXD]),
    .clr_i      (wr_clr),
    .set_o      (coll_set),
    .irq_o      (coll_irq_o)
  );

  bcd_start_gate i_start (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tx_en_i   (tx_en_q),
    .rx_start_i(ctrl_q.rx_start),
    .rx_fall_i (sync_fall[IDX_RXD]),
    .start_ok_o(tx_start_ok_o)
  );

  assign tx_en_o = tx_en_q;

  logic unused_bits;
  assign unused_bits = ^{reg_wdata_i, sync_lvl[IDX_TMR:IDX_XFER],
                         sync_fall[IDX_TMR:IDX_XFER], sync_rise[IDX_RXD]};
endmodule

// File: rtl/bcd_checker.sv
module bcd_checker
  import bcd_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       reg_wr_i,
  input logic [1:0] reg_addr_i,
  input logic       wdata0_i,
  input logic       tx_busy_i,
  input logic       tx_en_o,
  input logic       tx_start_ok_o,
  input logic       coll_irq_o,
  input ctrl_t      ctrl_q
);
  logic clr_req;
  assign clr_req = reg_wr_i && (reg_addr_i == ADDR_IRQCLR) && wdata0_i;

  AST_IRQ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coll_irq_o && !clr_req |=> coll_irq_o); // R7
  AST_IDLE_NO_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_busy_i |=> !$rose(coll_irq_o)); // R6
  AST_AUTO_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(coll_irq_o) && $past(ctrl_q.auto_clr) |-> !tx_en_o); // R8
  AST_START_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_ok_o |-> tx_en_o); // R11
  AST_START_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_q.rx_start |-> tx_start_ok_o == tx_en_o); // R10
endmodule

bind bus_collision_guard bcd_checker i_bcd_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .reg_wr_i     (reg_wr_i),
  .reg_addr_i   (reg_addr_i),
  .wdata0_i     (reg_wdata_i[0]),
  .tx_busy_i    (tx_busy_i),
  .tx_en_o      (tx_en_o),
  .tx_start_ok_o(tx_start_ok_o),
  .coll_irq_o   (coll_irq_o),
  .ctrl_q       (ctrl_q)
);

// File: tb/test_bus_collision_guard.sv
module test_bus_collision_guard;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic       xfer_clk = 1'b0, tmr_ovf = 1'b0, tx_busy = 1'b0;
  logic       txd = 1'b1, rxd = 1'b1;
  logic       tx_en, tx_start_ok, coll_irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bus_collision_guard i_bus_collision_guard (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .xfer_clk_i(xfer_clk), .tmr_ovf_i(tmr_ovf),
    .tx_busy_i(tx_busy), .txd_i(txd), .rxd_i(rxd), .tx_en_o(tx_en),
    .tx_start_ok_o(tx_start_ok), .coll_irq_o(coll_irq)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  function automatic logic [7:0] ctrl_byte(bit tmr, bit aclr, bit rxs);
    return {1'b0, rxs, aclr, tmr, 4'b0000};
  endfunction

  // kind 0: transfer clock rise, kind 1: timer overflow
  task automatic strobe(input bit kind);
    @(negedge clk);
    if (kind) tmr_ovf = 1'b1; else xfer_clk = 1'b1;
    idle(1);
    tmr_ovf = 1'b0;
    idle(4);
    xfer_clk = 1'b0;
    idle(4);
  endtask

  function automatic logic exp_irq(bit kind, bit tmr, bit busy, bit t, bit r);
    return busy && (t != r) && (kind == tmr);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    idle(3);
    rst_n = 1'b1;
    idle(2);
    chk("R1 tx_en", tx_en, 1'b0);
    chk("R1 start_ok", tx_start_ok, 1'b0);
    chk("R1 irq", coll_irq, 1'b0);
    // control reset to 0 means timer mode off: timer strobe ignored
    tx_busy = 1'b1; txd = 1'b0; rxd = 1'b1; idle(4);
    strobe(1);
    chk("R1 ctrl zero (timer ignored)", coll_irq, 1'b0);

    // R2/R10: enable via address 1
    wr(2'd1, 8'h01);
    idle(1);
    chk("R2 tx_en write", tx_en, 1'b1);
    chk("R10 start follows en", tx_start_ok, 1'b1);

    // R3 mismatch on xfer edge
    strobe(0);
    chk("R3 mismatch sets", coll_irq, 1'b1);
    chk("R9 no autoclear", tx_en, 1'b1);
    wr(2'd2, 8'h00);
    idle(1);
    chk("R7 write zero no clear", coll_irq, 1'b1);
    wr(2'd2, 8'h01);
    idle(1);
    chk("R2 clear", coll_irq, 1'b0);
    rxd = 1'b0; idle(4);
    strobe(0);
    chk("R3 match no set", coll_irq, 1'b0);

    // R4 timer ignored in xfer mode with mismatch
    rxd = 1'b1; idle(4);
    strobe(1);
    chk("R4 timer ignored", coll_irq, 1'b0);

    // R5 timer mode
    wr(2'd0, ctrl_byte(1, 0, 0));
    strobe(0);
    chk("R5 xfer ignored", coll_irq, 1'b0);
    strobe(1);
    chk("R5 timer samples", coll_irq, 1'b1);
    wr(2'd2, 8'h01);

    // R6 idle
    tx_busy = 1'b0; idle(2);
    strobe(1);
    chk("R6 idle no check", coll_irq, 1'b0);
    tx_busy = 1'b1;

    // R7 collision coincides with clear: set at third edge after drive
    wr(2'd0, ctrl_byte(0, 0, 0));
    strobe(0);
    chk("R7 pre-set", coll_irq, 1'b1);
    @(negedge clk); xfer_clk = 1'b1;
    @(negedge clk);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 8'h01;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
    chk("R7 set beats clear", coll_irq, 1'b1);
    idle(4); xfer_clk = 1'b0; idle(4);
    wr(2'd2, 8'h01);

    // R8 auto clear
    wr(2'd0, ctrl_byte(0, 1, 0));
    wr(2'd1, 8'h01);
    strobe(0);
    chk("R8 irq", coll_irq, 1'b1);
    chk("R8 tx_en cleared", tx_en, 1'b0);
    chk("R8 start dropped", tx_start_ok, 1'b0);
    wr(2'd2, 8'h01);
    tx_busy = 1'b0;

    // R11 start on RXD fall
    wr(2'd0, ctrl_byte(0, 0, 1));
    rxd = 1'b1; idle(4);
    rxd = 1'b0; idle(4);
    wr(2'd1, 8'h01);
    idle(4);
    chk("R11 early fall ignored", tx_start_ok, 1'b0);
    rxd = 1'b1; idle(4);
    chk("R11 rise no start", tx_start_ok, 1'b0);
    rxd = 1'b0; idle(4);
    chk("R11 fall after arm", tx_start_ok, 1'b1);
    wr(2'd1, 8'h00);
    idle(1);
    chk("R11 drop with en", tx_start_ok, 1'b0);
    rxd = 1'b1; idle(4);

    // random rounds
    for (int i = 0; i < 200; i++) begin
      bit tmr, aclr, kind, b, t, r;
      logic ei;
      tmr = 1'($urandom); aclr = 1'($urandom); kind = 1'($urandom);
      b = 1'($urandom); t = 1'($urandom); r = 1'($urandom);
      wr(2'd0, ctrl_byte(tmr, aclr, 0));
      wr(2'd1, 8'h01);
      wr(2'd2, 8'h01);
      tx_busy = b; txd = t; rxd = r;
      idle(4);
      strobe(kind);
      ei = exp_irq(kind, tmr, b, t, r);
      chk(tmr ? "R5 random irq" : "R3 random irq", coll_irq, ei);
      chk(aclr ? "R8 random en" : "R9 random en", tx_en, !(ei && aclr));
      chk("R10 random start", tx_start_ok, !(ei && aclr));
      tx_busy = 1'b0;
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule